// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from memory. A request arrives with its virtual address. The block samples the table base and a tiny-page support flag at the same moment. It then fetches a first-level descriptor, and when that descriptor points to a second-level table it fetches one more descriptor. Each fetch is a single 32-bit word read on a simple read port.

The first-level descriptor either maps a 1 MB section directly or points to a coarse table or a fine table. The second-level descriptor maps a 64 KB large page, a 4 KB small page or a 1 KB tiny page. The block returns the physical address, a two-bit cacheable/bufferable attribute and a fault flag, all held steady for one cycle with a done pulse. Only one walk runs at a time.

Top module: `pt_walker`

## Requirements
- R1: The first read address is the sampled table base with bits [13:0] cleared, ORed with virtual address bits [31:20] placed at bits [13:2]. Base and tiny-page flag are taken when the request is accepted.
- R2: First-level type bits [1:0]=10 (section): the physical address is descriptor [31:20] joined with virtual address [19:0], the attribute is descriptor [3:2], and no second read is made.
- R3: First-level type 01 (coarse): the second read address is descriptor [31:10] with virtual address [19:12] at bits [9:2].
- R4: First-level type 11 (fine) with tiny pages supported: the second read address is descriptor [31:12] with virtual address [19:10] at bits [11:2].
- R5: Second-level type bits [1:0] give the page. For 01 (large) the physical address is descriptor [31:16] with virtual address [15:0]. For 10 (small) it is descriptor [31:12] with virtual address [11:0]. For 11 (tiny) it is descriptor [31:10] with virtual address [9:0]. The attribute is descriptor [3:2].
- R6: Type 00 at either level is a fault, and a fault result has physical address zero and attribute 00.
- R7: First-level type 11 while the tiny-page flag is low is a fault, and no second read is made.
- R8: A read returned with the error flag set ends the walk at once as a fault.
- R9: req_ready drops after a request is accepted and stays low until the done pulse. done lasts exactly one cycle. A memory request holds its address until mem_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tbl_base | input | 32 | Translation table base, sampled on request accept |
| tiny_ok | input | 1 | Tiny pages and fine tables supported |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 32 | Virtual address to translate |
| mem_req | output | 1 | Memory read request |
| mem_ready | input | 1 | Memory accepts the read request |
| mem_addr | output | 32 | Word address of the descriptor read |
| mem_rvalid | input | 1 | Read data valid pulse |
| mem_rdata | input | 32 | Descriptor word returned |
| mem_err | input | 1 | Error response qualifying mem_rvalid |
| done | output | 1 | One-cycle result pulse |
| pa | output | 32 | Translated physical address |
| attr | output | 2 | Cacheable/bufferable attribute |
| fault | output | 1 | Translation fault |

## Verification
The block has no parameters. The bench sets the tiny-page flag high and low on different walks, so both the fine-table path and its rejection path are covered. Random descriptors of every type at both levels are mixed with injected read errors at either level. Random stalls on mem_ready and on read return exercise the hold rule on the request address.

// File: rtl/pt_walker.sv
module pt_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] tbl_base,
  input  logic        tiny_ok,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  output logic        mem_req,
  input  logic        mem_ready,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err,
  output logic        done,
  output logic [31:0] pa,
  output logic [1:0]  attr,
  output logic        fault
);
  typedef enum logic [2:0] {S_IDLE, S_L1REQ, S_L1WAIT, S_L2REQ, S_L2WAIT, S_DONE} st_t;
  st_t st;
  logic [31:0] va_q, addr_q, pa_q;
  logic [1:0]  attr_q;
  logic        tiny_q, fault_q;
  logic        unused_bits;

  assign req_ready = (st == S_IDLE);
  assign mem_req   = (st == S_L1REQ) || (st == S_L2REQ);
  assign mem_addr  = addr_q;
  assign done      = (st == S_DONE);
  assign pa        = pa_q;
  assign attr      = attr_q;
  assign fault     = fault_q;
  assign unused_bits = ^{mem_rdata[9:4], tbl_base[13:0]};

  wire [1:0]  dtype   = mem_rdata[1:0];
  wire [31:0] l1_addr = {tbl_base[31:14], req_va[31:20], 2'b00};
  wire [31:0] coarse_a = {mem_rdata[31:10], va_q[19:12], 2'b00};
  wire [31:0] fine_a   = {mem_rdata[31:12], va_q[19:10], 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      addr_q  <= '0;
      tiny_q  <= 1'b0;
      pa_q    <= '0;
      attr_q  <= '0;
      fault_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          va_q   <= req_va;
          tiny_q <= tiny_ok;
          addr_q <= l1_addr;
          st     <= S_L1REQ;
        end
        S_L1REQ: if (mem_ready) st <= S_L1WAIT;
        S_L1WAIT: if (mem_rvalid) begin
          if (mem_err || dtype == 2'b00 || (dtype == 2'b11 && !tiny_q)) begin
            pa_q <= '0; attr_q <= '0; fault_q <= 1'b1; st <= S_DONE;
          end else if (dtype == 2'b10) begin
            pa_q    <= {mem_rdata[31:20], va_q[19:0]};
            attr_q  <= mem_rdata[3:2];
            fault_q <= 1'b0;
            st      <= S_DONE;
          end else begin
            addr_q <= (dtype == 2'b01) ? coarse_a : fine_a;
            st     <= S_L2REQ;
          end
        end
        S_L2REQ: if (mem_ready) st <= S_L2WAIT;
        S_L2WAIT: if (mem_rvalid) begin
          st <= S_DONE;
          if (mem_err || dtype == 2'b00) begin
            pa_q <= '0; attr_q <= '0; fault_q <= 1'b1;
          end else begin
            attr_q  <= mem_rdata[3:2];
            fault_q <= 1'b0;
            case (dtype)
              2'b01:   pa_q <= {mem_rdata[31:16], va_q[15:0]};
              2'b10:   pa_q <= {mem_rdata[31:12], va_q[11:0]};
              default: pa_q <= {mem_rdata[31:10], va_q[9:0]};
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
  // R6
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (pa == 32'd0 && attr == 2'b00));
  // R8
  err_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rvalid && mem_err && !mem_req && !req_ready && !done) |=> (done && fault));
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic clk = 0, rst_n = 0;
  logic [31:0] tbl_base = 0, req_va = 0, mem_rdata = 0;
  logic tiny_ok = 0, req_valid = 0, mem_ready = 0, mem_rvalid = 0, mem_err = 0;
  logic req_ready, mem_req, done, fault;
  logic [31:0] mem_addr, pa;
  logic [1:0] attr;

  pt_walker dut (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  logic [31:0] d1, d2, alog0, alog1;
  int err_at, nreads;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        repeat ($urandom % 3) @(negedge clk);
        if (nreads == 0) alog0 = mem_addr; else alog1 = mem_addr;
        mem_ready = 1;
        @(negedge clk);
        mem_ready = 0;
        repeat ($urandom % 3) @(negedge clk);
        mem_rvalid = 1;
        mem_rdata = (nreads == 0) ? d1 : d2;
        mem_err = (err_at == nreads);
        nreads++;
        @(negedge clk);
        mem_rvalid = 0;
        mem_err = 0;
        mem_rdata = $urandom;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input bit tiny,
                      input logic [31:0] a, input logic [31:0] b, input int ea);
    logic [31:0] e_l1, e_l2, e_pa;
    logic [1:0] e_attr;
    bit e_fault;
    int e_reads, n;
    d1 = a; d2 = b; err_at = ea; nreads = 0;
    e_l1 = {base[31:14], va[31:20], 2'b00};
    e_l2 = 0; e_pa = 0; e_attr = 0; e_fault = 0; e_reads = 1;
    if (ea == 0 || a[1:0] == 2'b00 || (a[1:0] == 2'b11 && !tiny)) e_fault = 1;
    else if (a[1:0] == 2'b10) begin
      e_pa = {a[31:20], va[19:0]}; e_attr = a[3:2];
    end else begin
      e_reads = 2;
      e_l2 = (a[1:0] == 2'b01) ? {a[31:10], va[19:12], 2'b00} : {a[31:12], va[19:10], 2'b00};
      if (ea == 1 || b[1:0] == 2'b00) e_fault = 1;
      else begin
        e_attr = b[3:2];
        case (b[1:0])
          2'b01:   e_pa = {b[31:16], va[15:0]};
          2'b10:   e_pa = {b[31:12], va[11:0]};
          default: e_pa = {b[31:10], va[9:0]};
        endcase
      end
    end
    @(negedge clk);
    chk(req_ready === 1'b1, "R9 idle ready", {31'd0, req_ready}, 1);
    req_va = va; tbl_base = base; tiny_ok = tiny; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    tbl_base = $urandom; tiny_ok = $urandom;
    n = 0;
    while (!done && n < 100) begin
      if (req_ready) chk(0, "R9 ready low while busy", 1, 0);
      @(negedge clk); n++;
    end
    chk(done === 1'b1, "R9 done seen", {31'd0, done}, 1);
    chk(fault === e_fault, "R6 R7 R8 fault", {31'd0, fault}, {31'd0, e_fault});
    chk(pa === e_pa, "R2 R5 R6 pa", pa, e_pa);
    chk(attr === e_attr, "R2 R5 R6 attr", {30'd0, attr}, {30'd0, e_attr});
    chk(nreads == e_reads, "R2 R7 read count", nreads, e_reads);
    chk(alog0 === e_l1, "R1 first address", alog0, e_l1);
    if (e_reads == 2) chk(alog1 === e_l2, "R3 R4 second address", alog1, e_l2);
    @(negedge clk);
    chk(!done && req_ready, "R9 done one cycle", {30'd0, done, req_ready}, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk(!done && !mem_req && !fault && pa == 0 && attr == 0, "reset state", pa, 0);
    rst_n = 1;
    // R2 section
    walk(32'hABC1_2345, 32'h1234_5FFF, 1, 32'hFED0_000E, 0, -1);
    // R3 coarse + R5 small
    walk(32'h0037_F123, 32'h0000_8000, 0, 32'h4000_1401, 32'h9999_9006, -1);
    // R4 fine + R5 tiny
    walk(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 32'h1234_5FFF, 32'h8765_43FB, -1);
    // R5 large
    walk(32'h1234_5678, 32'h0000_0000, 1, 32'hAAAA_AC01, 32'hBEEF_0005, -1);
    // R6 faults at each level
    walk(32'h1111_1111, 32'h2222_2222, 1, 32'hFFFF_FFFC, 0, -1);
    walk(32'h1111_1111, 32'h2222_2222, 1, 32'hFFFF_FC01, 32'hFFFF_FFFC, -1);
    // R7 fine rejected
    walk(32'h0000_0000, 32'h0000_0000, 0, 32'h1234_5003, 32'h5555_5556, -1);
    // R8 errors at each level
    walk(32'h7654_3210, 32'h0004_0000, 1, 32'hFED0_000E, 0, 0);
    walk(32'h7654_3210, 32'h0004_0000, 1, 32'h0000_0401, 32'h1234_5006, 1);
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom % 8;
      walk($urandom, $urandom, $urandom, $urandom, $urandom, (r < 2) ? r : -1);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule